// File: doc/BRIEF.md
# Quiet-Window I2C Register Injector

This block is an I2C write master that shares a bus with a second master that never stops talking. On a start pulse it holds SCL low for a programmable number of milliseconds. This clock stretch makes the resident master back off and leave a long silent gap once SCL is let go. The block then releases SCL and times how long SCL stays high. A low sample seen from any source restarts that timer. Only when the measured high window has reached its minimum does it send its own traffic.

The traffic is a fixed burst of register writes to one 7-bit device address. Each write is a single frame: START, address byte with the write bit, a subaddress byte, a data high byte, a data low byte, and STOP. The frame contents sit in a small parameterised table that is read through a frame counter and a byte counter. Both bus lines are open drain. The block only drives a line low or leaves it released, and it samples both lines through two-flop synchronisers. Millisecond and bit timing come from system-clock dividers, so a test can shrink every interval.

Top module: `qwi_injector`

## Requirements
- R1: After reset, busy_o, done_o and error_o are 0, and neither scl_pull_o nor sda_pull_o is asserted.
- R2: A start_i pulse while idle raises busy_o and drives SCL low for exactly HOLD_MS*CLK_PER_MS system cycles, with SDA released the whole time.
- R3: After the hold, no START is sent until the synchronised SCL has been high for IDLE_MS*CLK_PER_MS consecutive cycles. Any low sample restarts the window, so the first START comes at least that many cycles after the last low on the line.
- R4: Each frame is START, then the address byte {DEV_ADDR, 0} (0xB0 for the default 0x58), then subaddress, high byte and low byte, then STOP. Every byte goes out MSB first and is followed by a ninth clock with SDA released for the acknowledge.
- R5: With default contents the burst is three frames in this order: (0x4B,0x81,0x08), (0x49,0xD7,0x5C), (0x3F,0x4A,0x07).
- R6: Within a byte, consecutive rising SCL edges are 4*QTR_CYCLES system cycles apart. The default gives a 50 kHz bit rate at a 50 MHz clock.
- R7: SDA changes only while SCL is low, except for the falling edge of START and the rising edge of STOP. A whole burst therefore shows exactly one START and one STOP per frame sent.
- R8: If SDA is high on the ninth clock of any byte, the block stops sending bytes, issues a STOP, sends no further frames, returns to idle with error_o = 1 and does not pulse done_o. error_o holds until the next accepted start.
- R9: After the STOP of the last frame, done_o is high for exactly one cycle. busy_o is then 0 and both lines are released.
- R10: start_i is ignored while busy_o is high: no second hold, no extra frames, a single done_o pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin one hold-wait-burst sequence (sampled while idle) |
| scl_i | input | 1 | Sampled level of the SCL line |
| sda_i | input | 1 | Sampled level of the SDA line |
| scl_pull_o | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_pull_o | output | 1 | 1 pulls SDA low, 0 releases it |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse after the final STOP of a complete burst |
| error_o | output | 1 | A byte was not acknowledged; held until the next start |

## Verification
The hardest conditions to reach are two. The first is an idle window that another bus user breaks partway through. The stimulus pulls the shared SCL line low in the middle of the wait, then measures from the moment of release to the first START. The second is a missing acknowledge at one exact byte of the burst. The slave model in the bench withholds the acknowledge at a chosen byte, and the sweep moves that byte across all twelve positions. For each position the bench predicts how many bytes, STARTs and STOPs must appear before the abort.

// File: rtl/qwi_pkg.sv
package qwi_pkg;

  // Bus-level operations handed from the sequencer to the bit engine
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_START = 2'd1,
    OP_BYTE  = 2'd2,
    OP_STOP  = 2'd3
  } qwi_op_e;

  // Sequencer states
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_HOLD  = 3'd1,
    ST_WAIT  = 3'd2,
    ST_START = 3'd3,
    ST_BYTE  = 3'd4,
    ST_STOP  = 3'd5
  } qwi_state_e;

  // address byte + subaddress + high + low
  localparam int unsigned BYTES_PER_FRAME = 4;

endpackage

// File: rtl/qwi_divider.sv
// Restartable modulo-DIV tick generator.
module qwi_divider #(
  parameter int unsigned DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);
  localparam int unsigned W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (clr)              cnt_d = '0;
    else if (cnt_q == LAST) cnt_d = '0;
    else                  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = !clr && (cnt_q == LAST);

endmodule

// File: rtl/qwi_sync.sv
// Two-flop synchroniser per bit; resets to the idle bus level.
module qwi_sync #(
  parameter int unsigned WIDTH   = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic meta_q, stab_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= RST_VAL;
        stab_q <= RST_VAL;
      end else begin
        meta_q <= d_i[i];
        stab_q <= meta_q;
      end
    end
    assign q_o[i] = stab_q;
  end

endmodule

// File: rtl/qwi_frame_rom.sv
// Frame table: entry f holds {subaddress, high, low}; frame 0 sits in the top 24 bits.
module qwi_frame_rom #(
  parameter int unsigned          NUM_FRAMES  = 3,
  parameter logic [6:0]           DEV_ADDR    = 7'h58,
  parameter logic [NUM_FRAMES*24-1:0] FRAME_WORDS = {24'h4B8108, 24'h49D75C, 24'h3F4A07},
  parameter int unsigned          FW          = 2
) (
  input  logic [FW-1:0] frame_idx,
  input  logic [1:0]    byte_idx,
  output logic [7:0]    byte_o
);
  logic [23:0] words [NUM_FRAMES];
  logic [23:0] word_sel;

  for (genvar f = 0; f < NUM_FRAMES; f++) begin : g_word
    assign words[f] = FRAME_WORDS[(NUM_FRAMES - f)*24 - 1 -: 24];
  end

  always_comb begin
    word_sel = '0;
    for (int f = 0; f < NUM_FRAMES; f++) begin
      if (frame_idx == FW'(f)) word_sel = words[f];
    end
  end

  always_comb begin
    case (byte_idx)
      2'd0:    byte_o = {DEV_ADDR, 1'b0};
      2'd1:    byte_o = word_sel[23:16];
      2'd2:    byte_o = word_sel[15:8];
      default: byte_o = word_sel[7:0];
    endcase
  end

endmodule

// File: rtl/qwi_bit_engine.sv
// Executes one START, byte (with acknowledge clock) or STOP per command.
// Each bus operation is four quarter phases of QTR_CYCLES system cycles.
module qwi_bit_engine
  import qwi_pkg::*;
#(
  parameter int unsigned QTR_CYCLES = 250
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_vld,
  input  qwi_op_e    cmd_op,
  input  logic [7:0] cmd_byte,
  input  logic       sda_in,
  output logic       scl_low_o,
  output logic       sda_low_o,
  output logic       op_done_o,
  output logic       nack_o
);
  qwi_op_e    op_q, op_d;
  logic [1:0] q_q, q_d;
  logic [3:0] bit_q, bit_d;
  logic [7:0] sh_q, sh_d;
  logic       nack_q, nack_d;
  logic       done_q, done_d;
  logic       scl_q, sda_q;
  logic       ph_scl, ph_sda;
  logic       qtick;

  qwi_divider #(.DIV(QTR_CYCLES)) u_qdiv (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (op_q == OP_IDLE),
    .tick (qtick)
  );

  // Line levels for the current phase (1 = pull low)
  always_comb begin
    ph_scl = scl_q;
    ph_sda = sda_q;
    case (op_q)
      OP_START: begin
        ph_scl = q_q[1];
        ph_sda = (q_q != 2'd0);
      end
      OP_BYTE: begin
        ph_scl = (q_q == 2'd0) || (q_q == 2'd3);
        ph_sda = (bit_q != 4'd8) && !sh_q[7];
      end
      OP_STOP: begin
        ph_scl = (q_q == 2'd0);
        ph_sda = !q_q[1];
      end
      default: ;
    endcase
  end

  // Next-state
  always_comb begin
    op_d   = op_q;
    q_d    = q_q;
    bit_d  = bit_q;
    sh_d   = sh_q;
    nack_d = nack_q;
    done_d = 1'b0;
    if (op_q == OP_IDLE) begin
      if (cmd_vld) begin
        op_d   = cmd_op;
        q_d    = 2'd0;
        bit_d  = 4'd0;
        sh_d   = cmd_byte;
        nack_d = 1'b0;
      end
    end else if (qtick) begin
      if (op_q == OP_BYTE && bit_q == 4'd8 && q_q == 2'd2) nack_d = sda_in;
      if (q_q == 2'd3) begin
        q_d = 2'd0;
        if (op_q == OP_BYTE && bit_q != 4'd8) begin
          bit_d = bit_q + 4'd1;
          sh_d  = {sh_q[6:0], 1'b0};
        end else begin
          op_d   = OP_IDLE;
          done_d = 1'b1;
        end
      end else begin
        q_d = q_q + 2'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_IDLE;
      q_q    <= 2'd0;
      bit_q  <= 4'd0;
      sh_q   <= 8'd0;
      nack_q <= 1'b0;
      done_q <= 1'b0;
      scl_q  <= 1'b0;
      sda_q  <= 1'b0;
    end else begin
      op_q   <= op_d;
      q_q    <= q_d;
      bit_q  <= bit_d;
      sh_q   <= sh_d;
      nack_q <= nack_d;
      done_q <= done_d;
      scl_q  <= ph_scl;
      sda_q  <= ph_sda;
    end
  end

  assign scl_low_o = scl_q;
  assign sda_low_o = sda_q;
  assign op_done_o = done_q;
  assign nack_o    = nack_q;

  AST_CMD_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_vld |-> (op_q == OP_IDLE)); // R10
  AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(op_q) == OP_BYTE && sda_q != $past(sda_q)) |-> (scl_q && $past(scl_q))); // R7

endmodule

// File: rtl/qwi_injector.sv
module qwi_injector
  import qwi_pkg::*;
#(
  parameter int unsigned              CLK_PER_MS  = 50000,
  parameter int unsigned              HOLD_MS     = 300,
  parameter int unsigned              IDLE_MS     = 200,
  parameter int unsigned              QTR_CYCLES  = 250,
  parameter logic [6:0]               DEV_ADDR    = 7'h58,
  parameter int unsigned              NUM_FRAMES  = 3,
  parameter logic [NUM_FRAMES*24-1:0] FRAME_WORDS = {24'h4B8108, 24'h49D75C, 24'h3F4A07}
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_pull_o,
  output logic sda_pull_o,
  output logic busy_o,
  output logic done_o,
  output logic error_o
);
  localparam int unsigned FW       = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1;
  localparam int unsigned MS_MAX   = (HOLD_MS > IDLE_MS) ? HOLD_MS : IDLE_MS;
  localparam int unsigned MSW      = $clog2(MS_MAX + 1);
  localparam logic [MSW-1:0] HOLD_LAST = MSW'(HOLD_MS - 1);
  localparam logic [MSW-1:0] IDLE_LAST = MSW'(IDLE_MS - 1);
  localparam logic [FW-1:0]  LAST_FRAME = FW'(NUM_FRAMES - 1);
  localparam logic [1:0]     LAST_BYTE  = 2'(BYTES_PER_FRAME - 1);
  localparam int unsigned HOLD_CYC = HOLD_MS * CLK_PER_MS;
  localparam int unsigned IDLE_CYC = IDLE_MS * CLK_PER_MS;
  localparam int unsigned CYC_MAX  = (HOLD_CYC > IDLE_CYC) ? HOLD_CYC : IDLE_CYC;
  localparam int unsigned CW       = $clog2(CYC_MAX + 2);

  // ---------------------------------------------------------------- inputs
  logic [1:0] bus_s;
  logic       scl_s, sda_s;

  qwi_sync #(.WIDTH(2), .RST_VAL(1'b1)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  ({scl_i, sda_i}),
    .q_o  (bus_s)
  );
  assign scl_s = bus_s[1];
  assign sda_s = bus_s[0];

  // ---------------------------------------------------------------- state
  qwi_state_e     state_q, state_d;
  logic [MSW-1:0] ms_q, ms_d;
  logic [FW-1:0]  frame_q, frame_d;
  logic [1:0]     bidx_q, bidx_d;
  logic           abort_q, abort_d;
  logic           err_q, err_d;
  logic           done_q, done_d;
  logic           cmd_vld_q, cmd_vld_d;
  qwi_op_e        cmd_op_q, cmd_op_d;

  logic       ms_clr, ms_tick;
  logic [7:0] rom_byte;
  logic       eng_scl, eng_sda, eng_done, eng_nack;

  // Millisecond timer runs only while holding, or while waiting with SCL seen high
  assign ms_clr = !((state_q == ST_HOLD) || (state_q == ST_WAIT && scl_s));

  qwi_divider #(.DIV(CLK_PER_MS)) u_msdiv (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (ms_clr),
    .tick (ms_tick)
  );

  qwi_frame_rom #(
    .NUM_FRAMES (NUM_FRAMES),
    .DEV_ADDR   (DEV_ADDR),
    .FRAME_WORDS(FRAME_WORDS),
    .FW         (FW)
  ) u_rom (
    .frame_idx(frame_q),
    .byte_idx (bidx_q),
    .byte_o   (rom_byte)
  );

  qwi_bit_engine #(.QTR_CYCLES(QTR_CYCLES)) u_eng (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_vld  (cmd_vld_q),
    .cmd_op   (cmd_op_q),
    .cmd_byte (rom_byte),
    .sda_in   (sda_s),
    .scl_low_o(eng_scl),
    .sda_low_o(eng_sda),
    .op_done_o(eng_done),
    .nack_o   (eng_nack)
  );

  // ---------------------------------------------------------------- sequencer
  always_comb begin
    state_d   = state_q;
    ms_d      = ms_q;
    frame_d   = frame_q;
    bidx_d    = bidx_q;
    abort_d   = abort_q;
    err_d     = err_q;
    done_d    = 1'b0;
    cmd_vld_d = 1'b0;
    cmd_op_d  = cmd_op_q;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_HOLD;
          ms_d    = '0;
          err_d   = 1'b0;
          abort_d = 1'b0;
        end
      end
      ST_HOLD: begin
        if (ms_tick) begin
          if (ms_q == HOLD_LAST) begin
            state_d = ST_WAIT;
            ms_d    = '0;
          end else begin
            ms_d = ms_q + 1'b1;
          end
        end
      end
      ST_WAIT: begin
        if (!scl_s) begin
          ms_d = '0;
        end else if (ms_tick) begin
          if (ms_q == IDLE_LAST) begin
            state_d   = ST_START;
            ms_d      = '0;
            frame_d   = '0;
            cmd_vld_d = 1'b1;
            cmd_op_d  = OP_START;
          end else begin
            ms_d = ms_q + 1'b1;
          end
        end
      end
      ST_START: begin
        if (eng_done) begin
          state_d   = ST_BYTE;
          bidx_d    = 2'd0;
          cmd_vld_d = 1'b1;
          cmd_op_d  = OP_BYTE;
        end
      end
      ST_BYTE: begin
        if (eng_done) begin
          if (eng_nack || bidx_q == LAST_BYTE) begin
            state_d   = ST_STOP;
            abort_d   = eng_nack;
            cmd_vld_d = 1'b1;
            cmd_op_d  = OP_STOP;
          end else begin
            bidx_d    = bidx_q + 2'd1;
            cmd_vld_d = 1'b1;
            cmd_op_d  = OP_BYTE;
          end
        end
      end
      ST_STOP: begin
        if (eng_done) begin
          if (abort_q) begin
            state_d = ST_IDLE;
            err_d   = 1'b1;
            abort_d = 1'b0;
          end else if (frame_q == LAST_FRAME) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end else begin
            state_d   = ST_START;
            frame_d   = frame_q + 1'b1;
            cmd_vld_d = 1'b1;
            cmd_op_d  = OP_START;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      ms_q      <= '0;
      frame_q   <= '0;
      bidx_q    <= 2'd0;
      abort_q   <= 1'b0;
      err_q     <= 1'b0;
      done_q    <= 1'b0;
      cmd_vld_q <= 1'b0;
      cmd_op_q  <= OP_IDLE;
    end else begin
      state_q   <= state_d;
      ms_q      <= ms_d;
      frame_q   <= frame_d;
      bidx_q    <= bidx_d;
      abort_q   <= abort_d;
      err_q     <= err_d;
      done_q    <= done_d;
      cmd_vld_q <= cmd_vld_d;
      cmd_op_q  <= cmd_op_d;
    end
  end

  assign scl_pull_o = (state_q == ST_HOLD) | eng_scl;
  assign sda_pull_o = eng_sda;
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = done_q;
  assign error_o    = err_q;

  // ---------------------------------------------------------------- checks
  // Independent cycle counters for the hold length and the SCL-high run
  logic [CW-1:0] hold_cyc_q, high_cyc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_cyc_q <= '0;
      high_cyc_q <= '0;
    end else begin
      hold_cyc_q <= (state_q == ST_HOLD) ? hold_cyc_q + 1'b1 : '0;
      if (!scl_s)                high_cyc_q <= '0;
      else if (high_cyc_q != '1) high_cyc_q <= high_cyc_q + 1'b1;
    end
  end

  AST_HOLD_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HOLD && state_d == ST_WAIT) |-> (int'(hold_cyc_q) + 1 == HOLD_CYC)); // R2
  AST_IDLE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && state_d == ST_START) |-> (int'(high_cyc_q) + 1 >= IDLE_CYC)); // R3
  AST_QUIET_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT) |-> (!scl_pull_o && !sda_pull_o)); // R3
  AST_ABORT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_STOP && abort_q && eng_done) |=> (error_o && !busy_o && !done_o)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R9
  AST_DONE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!scl_pull_o && !sda_pull_o && !busy_o)); // R9
  AST_ERR_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    error_o |-> !done_o); // R8

endmodule

// File: tb/qwi_injector_tb_top.sv
module qwi_injector_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CPM        = 20;
  localparam int HOLD_MS    = 3;
  localparam int IDLE_MS    = 2;
  localparam int QTR        = 4;
  localparam int HOLD_CYC   = HOLD_MS * CPM;
  localparam int IDLE_CYC   = IDLE_MS * CPM;
  localparam int N_BYTES    = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic bench_scl_low = 1'b0;
  logic slave_sda_low = 1'b0;
  logic scl_pull, sda_pull, busy, done, error;
  logic scl_line, sda_line;

  assign scl_line = !(scl_pull | bench_scl_low);
  assign sda_line = !(sda_pull | slave_sda_low);

  qwi_injector #(
    .CLK_PER_MS(CPM), .HOLD_MS(HOLD_MS), .IDLE_MS(IDLE_MS), .QTR_CYCLES(QTR)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .scl_i(scl_line), .sda_i(sda_line),
    .scl_pull_o(scl_pull), .sda_pull_o(sda_pull),
    .busy_o(busy), .done_o(done), .error_o(error)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // ---------------------------------------------------------- slave model
  int n_starts = 0, n_stops = 0, n_bytes = 0, bitcnt = 0, nack_at = 99;
  int byte_log [0:63];
  logic [7:0] shv = 8'd0;
  time t_b0 = 0, t_b1 = 0;
  int done_hits = 0;

  always @(negedge sda_line) if (scl_line === 1'b1) begin
    n_starts++;
    bitcnt = 0;
  end
  always @(posedge sda_line) if (scl_line === 1'b1) n_stops++;

  always @(posedge scl_line) begin
    if (n_bytes == 0 && bitcnt == 0) t_b0 = $time;
    if (n_bytes == 0 && bitcnt == 1) t_b1 = $time;
    if (bitcnt < 8) shv = {shv[6:0], sda_line};
    bitcnt++;
  end

  always @(negedge scl_line) begin
    if (bitcnt == 8) begin
      if (n_bytes < 64) byte_log[n_bytes] = int'(shv);
      slave_sda_low = (n_bytes != nack_at);
      n_bytes++;
    end else if (bitcnt == 9) begin
      slave_sda_low = 1'b0;
      bitcnt = 0;
    end
  end

  always @(negedge clk) if (done === 1'b1) done_hits++;

  function automatic int exp_byte(input int i);
    logic [23:0] w;
    int b;
    case (i / 4)
      0:       w = 24'h4B8108;
      1:       w = 24'h49D75C;
      default: w = 24'h3F4A07;
    endcase
    b = i % 4;
    if (b == 0) return (32'h58 << 1);
    return int'((w >> (8 * (3 - b))) & 24'hFF);
  endfunction

  task automatic clear_log(input int nk);
    n_starts = 0; n_stops = 0; n_bytes = 0; done_hits = 0; nack_at = nk;
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_idle();
    for (int g = 0; g < 20000 && busy; g++) @(negedge clk);
    repeat (5) @(negedge clk);
  endtask

  // ---------------------------------------------------------- watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  // ---------------------------------------------------------- tests
  initial begin
    int cnt;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 error", int'(error), 0);
    chk("R1 scl released", int'(scl_pull), 0);
    chk("R1 sda released", int'(sda_pull), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 busy after release", int'(busy), 0);

    // ---- normal burst with hold and window timing
    clear_log(99);
    pulse_start();
    chk("R2 busy during hold", int'(busy), 1);
    cnt = 0;
    while (scl_line == 1'b0 && cnt < 10000) begin
      if (sda_line != 1'b1) chk("R2 sda released in hold", 0, 1);
      cnt++;
      @(negedge clk);
    end
    chk("R2 hold length", cnt, HOLD_CYC);
    // R10 start while busy must be ignored
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    cnt = 2;
    while (n_starts == 0 && cnt < 10000) begin cnt++; @(negedge clk); end
    chk("R3 window lower bound", int'(cnt >= IDLE_CYC), 1);
    chk("R3 window upper bound", int'(cnt <= IDLE_CYC + 4*QTR + 8), 1);
    wait_idle();
    chk("R4 byte count", n_bytes, N_BYTES);
    for (int i = 0; i < N_BYTES; i++) chk($sformatf("R5 byte %0d", i), byte_log[i], exp_byte(i));
    chk("R4 address byte", byte_log[0], 'hB0);
    chk("R6 bit period", int'((t_b1 - t_b0) / CLK_PERIOD), 4*QTR);
    chk("R7 start count", n_starts, 3);
    chk("R7 stop count", n_stops, 3);
    chk("R9 done pulse width", done_hits, 1);
    chk("R9 scl released", int'(scl_line), 1);
    chk("R9 sda released", int'(sda_line), 1);
    chk("R8 no error", int'(error), 0);
    repeat (HOLD_CYC) @(negedge clk);
    chk("R10 no second burst", n_starts, 3);
    chk("R10 idle after burst", int'(busy), 0);

    // ---- idle window broken by another master
    clear_log(99);
    pulse_start();
    while (scl_line == 1'b0) @(negedge clk);
    repeat (IDLE_CYC / 2) @(negedge clk);
    chk("R3 no start before window", n_starts, 0);
    bench_scl_low = 1'b1;
    repeat (3) @(negedge clk);
    bench_scl_low = 1'b0;
    repeat (IDLE_CYC - 4) @(negedge clk);
    bench_scl_low = 1'b1;
    repeat (2) @(negedge clk);
    bench_scl_low = 1'b0;
    chk("R3 no start after late low", n_starts, 0);
    cnt = 0;
    while (n_starts == 0 && cnt < 10000) begin cnt++; @(negedge clk); end
    chk("R3 window restarted", int'(cnt >= IDLE_CYC), 1);
    wait_idle();
    chk("R5 bytes after restart", n_bytes, N_BYTES);
    chk("R9 done after restart", done_hits, 1);

    // ---- acknowledge withheld at every byte position
    for (int p = 0; p < N_BYTES; p++) begin
      clear_log(p);
      pulse_start();
      chk($sformatf("R8 error cleared by start p=%0d", p), int'(error), 0);
      wait_idle();
      chk($sformatf("R8 bytes p=%0d", p), n_bytes, p + 1);
      chk($sformatf("R8 starts p=%0d", p), n_starts, p / 4 + 1);
      chk($sformatf("R8 stops p=%0d", p), n_stops, p / 4 + 1);
      chk($sformatf("R8 error p=%0d", p), int'(error), 1);
      chk($sformatf("R8 no done p=%0d", p), done_hits, 0);
      chk($sformatf("R8 lines released p=%0d", p), int'(scl_line & sda_line), 1);
    end
    repeat (50) @(negedge clk);
    chk("R8 error held", int'(error), 1);

    // ---- clean run after errors
    clear_log(99);
    pulse_start();
    wait_idle();
    chk("R8 error cleared", int'(error), 0);
    chk("R5 final run bytes", n_bytes, N_BYTES);
    chk("R9 final done", done_hits, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule